// File: doc/BRIEF.md
# Burst End Predictor for One Slave Port

This block follows the transfers that the currently granted master issues to one slave port. It tells the slave's arbiter on which beats a re-arbitration is allowed. Single transfers and the last beat of fixed-length bursts are always such points. Open-ended incrementing bursts are cut at a programmable beat boundary, taken from the word address. A separate per-master beat budget forces a break when one master keeps the slave for too long. The arbiter combines `end_of_burst` and `slot_limit_hit` as it sees fit. Arbitration itself is not part of the block.

All three outputs are combinational. They are decoded from the current address-phase beat together with the registered tracking state. A beat counts only when `htrans` is NONSEQ or SEQ and `hready` is high. The tracker is a three-state machine:

- ST_IDLE: no burst is open.
- ST_DEFINED: a fixed-length burst is in progress, with a beat index.
- ST_UNDEF: an open-ended incrementing burst is in progress.

Its transitions are:

- T_OPEN_DEF: a non-final beat of a fixed-length burst, taking ST_IDLE or ST_UNDEF to ST_DEFINED.
- T_STEP_DEF: a non-final SEQ beat, keeping ST_DEFINED and advancing the index.
- T_CLOSE_DEF: the final beat, taking ST_DEFINED to ST_IDLE.
- T_OPEN_UNDEF: an open-ended incrementing beat, going to ST_UNDEF.
- T_TO_SINGLE: a single beat, going to ST_IDLE.
- T_DROP: a new grant with no beat, going to ST_IDLE.

Top module: `bep_predictor`

## Requirements
- R1: While reset is asserted, and on any cycle whose `htrans` is IDLE (0) or BUSY (1) or whose `hready` is low, all three outputs are 0.
- R2: A NONSEQ (2) beat with `hburst` SINGLE (0) drives `single_access` and `end_of_burst` to 1.
- R3: For fixed-length bursts, `hburst` WRAP4/INCR4 (2/3), WRAP8/INCR8 (4/5) or WRAP16/INCR16 (6/7), `end_of_burst` is 1 only on the 4th, 8th or 16th accepted beat after the NONSEQ. BUSY and stall cycles do not advance the count.
- R4: A NONSEQ beat arriving before a fixed-length burst has finished restarts the beat count at the first beat.
- R5: With `ulbt_mode` 0 (unlimited), an `hburst` INCR (1) beat never drives `end_of_burst`, whatever its address.
- R6: With `ulbt_mode` 1, every INCR beat drives `end_of_burst`.
- R7: With `ulbt_mode` m in 2..7, an INCR beat drives `end_of_burst` exactly when `waddr[m-1:0]` is all ones. The boundaries are 4, 8, 16, 32, 64 and 128 beats.
- R8: `slot_limit_hit` is 1 on an accepted beat when the number of accepted beats since the last grant or reset, including this one, is at least `slot_limit`. A limit of 0 disables it.
- R9: A cycle with `new_grant` high restarts the beat budget, so that cycle's beat counts as the first.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| new_grant | input | 1 | A different master is granted starting this cycle |
| htrans | input | 2 | Transfer type: 0 IDLE, 1 BUSY, 2 NONSEQ, 3 SEQ |
| hburst | input | 3 | Burst type: 0 SINGLE, 1 INCR, 2..7 fixed-length |
| hready | input | 1 | Bus ready; the beat is accepted when high |
| waddr | input | MAX_LOG2 (7) | Word-address bits (byte address bits 8:2) |
| ulbt_mode | input | 3 | Open-ended burst break size, 0 = unlimited |
| slot_limit | input | SLOT_W (8) | Beat budget per grant, 0 = no limit |
| end_of_burst | output | 1 | The current beat is a re-arbitration point |
| slot_limit_hit | output | 1 | The current beat exhausts the master's budget |
| single_access | output | 1 | The current beat is a single transfer |

## Verification
The bench goes after the beat counter. BUSY and stall cycles inside a fixed-length burst must not advance it, so a design that counted cycles instead of beats would flag the end one beat early. An early NONSEQ must restart the count; a tracker that ignored it would close the new burst too soon. The address boundary is exercised for every break size, including the 128-beat case on the top address bit, and with unlimited mode on all-ones addresses. An off-by-one in the mask would flag the wrong beat. The beat budget is checked for saturation past the limit, for restarting on a grant that arrives together with a beat, for a limit of zero and for being cleared by reset. A counter that was not cleared would raise the hit on the first beat after reset.

// File: rtl/bep_pkg.sv
package bep_pkg;

    typedef enum logic [1:0] {
        TR_IDLE   = 2'd0,
        TR_BUSY   = 2'd1,
        TR_NONSEQ = 2'd2,
        TR_SEQ    = 2'd3
    } trans_e;

    typedef enum logic [2:0] {
        BU_SINGLE = 3'd0,
        BU_INCR   = 3'd1,
        BU_WRAP4  = 3'd2,
        BU_INCR4  = 3'd3,
        BU_WRAP8  = 3'd4,
        BU_INCR8  = 3'd5,
        BU_WRAP16 = 3'd6,
        BU_INCR16 = 3'd7
    } burst_e;

    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_DEFINED = 2'd1,
        ST_UNDEF   = 2'd2
    } trk_state_e;

    // longest fixed-length burst and the index width it needs
    localparam int DEF_MAX_BEATS = 16;
    localparam int DEF_IDX_W     = $clog2(DEF_MAX_BEATS);
    localparam int DEF_LEN_W     = DEF_IDX_W + 1;

    function automatic logic [DEF_LEN_W-1:0] burst_beats(input logic [2:0] hb);
        logic [DEF_LEN_W-1:0] n;
        unique case (burst_e'(hb))
            BU_WRAP4,  BU_INCR4:  n = DEF_LEN_W'(4);
            BU_WRAP8,  BU_INCR8:  n = DEF_LEN_W'(8);
            BU_WRAP16, BU_INCR16: n = DEF_LEN_W'(16);
            default:              n = '0;
        endcase
        return n;
    endfunction

endpackage

// File: rtl/bep_boundary.sv
module bep_boundary #(
    parameter int MAX_LOG2 = 7
) (
    input  logic [2:0]          mode,
    input  logic [MAX_LOG2-1:0] waddr,
    output logic                brk
);
    localparam int N_MODES = 1 << 3;

    logic [N_MODES-1:0] ones_up_to;

    // ones_up_to[k] : the lowest k word-address bits are all ones
    assign ones_up_to[0] = 1'b1;
    generate
        for (genvar k = 1; k < N_MODES; k++) begin : g_mask
            if (k <= MAX_LOG2) begin : g_live
                assign ones_up_to[k] = &waddr[k-1:0];
            end else begin : g_none
                assign ones_up_to[k] = 1'b0;
            end
        end
    endgenerate

    always_comb begin
        unique case (mode)
            3'd0:    brk = 1'b0;           // unlimited
            3'd1:    brk = 1'b1;           // every beat
            default: brk = ones_up_to[mode];
        endcase
    end
endmodule

// File: rtl/bep_slot_counter.sv
module bep_slot_counter #(
    parameter int SLOT_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              restart,
    input  logic              beat,
    input  logic [SLOT_W-1:0] limit,
    output logic              hit
);
    localparam logic [SLOT_W-1:0] CNT_MAX = '1;

    logic [SLOT_W-1:0] cnt_q;
    logic [SLOT_W-1:0] prior;
    logic [SLOT_W-1:0] this_beat;

    always_comb begin
        prior     = restart ? '0 : cnt_q;
        this_beat = (prior == CNT_MAX) ? CNT_MAX : prior + 1'b1;
        hit       = beat && (limit != '0) && (this_beat >= limit);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= beat ? this_beat : prior;
        end
    end
endmodule

// File: rtl/bep_burst_tracker.sv
module bep_burst_tracker
    import bep_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       new_grant,
    input  logic       beat,
    input  logic [1:0] htrans,
    input  logic [2:0] hburst,
    output logic       def_last
);
    trk_state_e           state_q, state_d;
    logic [DEF_IDX_W-1:0] idx_q, idx_d;
    logic [DEF_IDX_W-1:0] cur_idx;
    logic [DEF_LEN_W-1:0] len;
    logic                 is_def;
    logic                 is_seq;

    always_comb begin
        is_seq   = (trans_e'(htrans) == TR_SEQ);
        len      = burst_beats(hburst);
        is_def   = (len != '0);
        cur_idx  = (is_seq && state_q == ST_DEFINED) ? idx_q : '0;
        def_last = beat && is_def && ({1'b0, cur_idx} == len - 1'b1);
    end

    // next state
    always_comb begin
        state_d = state_q;
        idx_d   = idx_q;
        unique case (state_q)
            ST_IDLE, ST_UNDEF: begin
                if (beat && is_def) begin                 // T_OPEN_DEF
                    state_d = ST_DEFINED;
                    idx_d   = cur_idx + 1'b1;
                end else if (beat && burst_e'(hburst) == BU_INCR) begin
                    state_d = ST_UNDEF;                   // T_OPEN_UNDEF
                    idx_d   = '0;
                end else if (beat) begin                  // T_TO_SINGLE
                    state_d = ST_IDLE;
                    idx_d   = '0;
                end else if (new_grant) begin             // T_DROP
                    state_d = ST_IDLE;
                    idx_d   = '0;
                end
            end
            ST_DEFINED: begin
                if (beat && is_def && def_last) begin     // T_CLOSE_DEF
                    state_d = ST_IDLE;
                    idx_d   = '0;
                end else if (beat && is_def) begin        // T_STEP_DEF / restart
                    state_d = ST_DEFINED;
                    idx_d   = cur_idx + 1'b1;
                end else if (beat && burst_e'(hburst) == BU_INCR) begin
                    state_d = ST_UNDEF;                   // T_OPEN_UNDEF
                    idx_d   = '0;
                end else if (beat) begin                  // T_TO_SINGLE
                    state_d = ST_IDLE;
                    idx_d   = '0;
                end else if (new_grant) begin             // T_DROP
                    state_d = ST_IDLE;
                    idx_d   = '0;
                end
            end
            default: begin
                state_d = ST_IDLE;
                idx_d   = '0;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            idx_q   <= '0;
        end else begin
            state_q <= state_d;
            idx_q   <= idx_d;
        end
    end
endmodule

// File: rtl/bep_predictor.sv
module bep_predictor
    import bep_pkg::*;
#(
    parameter int MAX_LOG2 = 7,
    parameter int SLOT_W   = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                new_grant,
    input  logic [1:0]          htrans,
    input  logic [2:0]          hburst,
    input  logic                hready,
    input  logic [MAX_LOG2-1:0] waddr,
    input  logic [2:0]          ulbt_mode,
    input  logic [SLOT_W-1:0]   slot_limit,
    output logic                end_of_burst,
    output logic                slot_limit_hit,
    output logic                single_access
);
    logic beat;
    logic def_last;
    logic incr_brk;
    logic budget_hit;

    assign beat = rst_n && hready &&
                  (trans_e'(htrans) == TR_NONSEQ || trans_e'(htrans) == TR_SEQ);

    bep_burst_tracker u_trk (
        .clk       (clk),
        .rst_n     (rst_n),
        .new_grant (new_grant),
        .beat      (beat),
        .htrans    (htrans),
        .hburst    (hburst),
        .def_last  (def_last)
    );

    bep_boundary #(.MAX_LOG2(MAX_LOG2)) u_bnd (
        .mode  (ulbt_mode),
        .waddr (waddr),
        .brk   (incr_brk)
    );

    bep_slot_counter #(.SLOT_W(SLOT_W)) u_slot (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (new_grant),
        .beat    (beat),
        .limit   (slot_limit),
        .hit     (budget_hit)
    );

    // outputs
    always_comb begin
        single_access  = beat && trans_e'(htrans) == TR_NONSEQ &&
                         burst_e'(hburst) == BU_SINGLE;
        slot_limit_hit = budget_hit;
        end_of_burst   = 1'b0;
        if (beat) begin
            unique case (burst_e'(hburst))
                BU_SINGLE: end_of_burst = 1'b1;
                BU_INCR:   end_of_burst = incr_brk;
                default:   end_of_burst = def_last;
            endcase
        end
    end
endmodule

// File: rtl/bep_predictor_chk.sv
module bep_predictor_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       new_grant,
    input logic [1:0] htrans,
    input logic [2:0] hburst,
    input logic       hready,
    input logic [1:0] waddr_lo,
    input logic [2:0] ulbt_mode,
    input logic [7:0] slot_limit,
    input logic       end_of_burst,
    input logic       slot_limit_hit,
    input logic       single_access
);
    logic acc;
    assign acc = hready && htrans[1];

    assert_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !acc |-> !end_of_burst && !slot_limit_hit && !single_access);

    assert_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && htrans == 2'd2 && hburst == 3'd0) |-> single_access && end_of_burst);

    assert_unlimited_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && hburst == 3'd1 && ulbt_mode == 3'd0) |-> !end_of_burst);

    assert_every_beat_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && hburst == 3'd1 && ulbt_mode == 3'd1) |-> end_of_burst);

    assert_boundary_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && hburst == 3'd1 && ulbt_mode >= 3'd2 && waddr_lo != 2'b11) |-> !end_of_burst);

    assert_no_limit_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (slot_limit == 8'd0) |-> !slot_limit_hit);

    assert_grant_restart_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (new_grant && slot_limit > 8'd1) |-> !slot_limit_hit);
endmodule

bind bep_predictor bep_predictor_chk u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .new_grant      (new_grant),
    .htrans         (htrans),
    .hburst         (hburst),
    .hready         (hready),
    .waddr_lo       (waddr[1:0]),
    .ulbt_mode      (ulbt_mode),
    .slot_limit     (slot_limit[7:0]),
    .end_of_burst   (end_of_burst),
    .slot_limit_hit (slot_limit_hit),
    .single_access  (single_access)
);

// File: tb/bep_predictor_test.sv
module bep_predictor_test;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       new_grant = 1'b0;
    logic [1:0] htrans = 2'd0;
    logic [2:0] hburst = 3'd0;
    logic       hready = 1'b1;
    logic [6:0] waddr = '0;
    logic [2:0] ulbt_mode = 3'd0;
    logic [7:0] slot_limit = 8'd0;
    logic       end_of_burst, slot_limit_hit, single_access;

    int n_run  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;   // 50 MHz

    bep_predictor uut (
        .clk(clk), .rst_n(rst_n), .new_grant(new_grant), .htrans(htrans),
        .hburst(hburst), .hready(hready), .waddr(waddr), .ulbt_mode(ulbt_mode),
        .slot_limit(slot_limit), .end_of_burst(end_of_burst),
        .slot_limit_hit(slot_limit_hit), .single_access(single_access)
    );

    typedef struct packed {
        logic [3:0] req;
        logic       g;
        logic [1:0] tr;
        logic [2:0] hb;
        logic       hr;
        logic [6:0] wa;
        logic [2:0] md;
        logic [7:0] lim;
        logic       e;
        logic       s;
        logic       si;
    } vec_t;

    localparam int NV = 46;
    // tr: 0 IDLE 1 BUSY 2 NONSEQ 3 SEQ; hb: 0 SINGLE 1 INCR 3 INCR4 4 WRAP8
    localparam vec_t VEC [NV] = '{
        '{4'd1, 1'b1, 2'd0, 3'd0, 1'b1, 7'd0,   3'd0, 8'd0, 1'b0, 1'b0, 1'b0}, // R1 idle
        '{4'd2, 1'b0, 2'd2, 3'd0, 1'b1, 7'd0,   3'd0, 8'd0, 1'b1, 1'b0, 1'b1}, // R2 single
        '{4'd3, 1'b0, 2'd2, 3'd3, 1'b1, 7'd4,   3'd0, 8'd0, 1'b0, 1'b0, 1'b0}, // R3 INCR4 beat 1
        '{4'd3, 1'b0, 2'd3, 3'd3, 1'b1, 7'd5,   3'd0, 8'd0, 1'b0, 1'b0, 1'b0},
        '{4'd1, 1'b0, 2'd1, 3'd3, 1'b1, 7'd6,   3'd0, 8'd0, 1'b0, 1'b0, 1'b0}, // R1 busy
        '{4'd3, 1'b0, 2'd3, 3'd3, 1'b1, 7'd6,   3'd0, 8'd0, 1'b0, 1'b0, 1'b0},
        '{4'd1, 1'b0, 2'd3, 3'd3, 1'b0, 7'd7,   3'd0, 8'd0, 1'b0, 1'b0, 1'b0}, // R1 stall
        '{4'd3, 1'b0, 2'd3, 3'd3, 1'b1, 7'd7,   3'd0, 8'd0, 1'b1, 1'b0, 1'b0}, // R3 4th beat
        '{4'd3, 1'b0, 2'd2, 3'd4, 1'b1, 7'd8,   3'd0, 8'd0, 1'b0, 1'b0, 1'b0}, // R3 WRAP8
        '{4'd3, 1'b0, 2'd3, 3'd4, 1'b1, 7'd9,   3'd0, 8'd0, 1'b0, 1'b0, 1'b0},
        '{4'd3, 1'b0, 2'd3, 3'd4, 1'b1, 7'd10,  3'd0, 8'd0, 1'b0, 1'b0, 1'b0},
        '{4'd3, 1'b0, 2'd3, 3'd4, 1'b1, 7'd11,  3'd0, 8'd0, 1'b0, 1'b0, 1'b0},
        '{4'd3, 1'b0, 2'd3, 3'd4, 1'b1, 7'd12,  3'd0, 8'd0, 1'b0, 1'b0, 1'b0},
        '{4'd3, 1'b0, 2'd3, 3'd4, 1'b1, 7'd13,  3'd0, 8'd0, 1'b0, 1'b0, 1'b0},
        '{4'd3, 1'b0, 2'd3, 3'd4, 1'b1, 7'd14,  3'd0, 8'd0, 1'b0, 1'b0, 1'b0},
        '{4'd3, 1'b0, 2'd3, 3'd4, 1'b1, 7'd15,  3'd0, 8'd0, 1'b1, 1'b0, 1'b0}, // R3 8th beat
        '{4'd4, 1'b0, 2'd2, 3'd3, 1'b1, 7'd0,   3'd0, 8'd0, 1'b0, 1'b0, 1'b0}, // R4
        '{4'd4, 1'b0, 2'd3, 3'd3, 1'b1, 7'd1,   3'd0, 8'd0, 1'b0, 1'b0, 1'b0},
        '{4'd4, 1'b0, 2'd2, 3'd3, 1'b1, 7'd2,   3'd0, 8'd0, 1'b0, 1'b0, 1'b0}, // R4 restart
        '{4'd4, 1'b0, 2'd3, 3'd3, 1'b1, 7'd3,   3'd0, 8'd0, 1'b0, 1'b0, 1'b0},
        '{4'd4, 1'b0, 2'd3, 3'd3, 1'b1, 7'd4,   3'd0, 8'd0, 1'b0, 1'b0, 1'b0},
        '{4'd4, 1'b0, 2'd3, 3'd3, 1'b1, 7'd5,   3'd0, 8'd0, 1'b1, 1'b0, 1'b0},
        '{4'd5, 1'b0, 2'd2, 3'd1, 1'b1, 7'd15,  3'd0, 8'd0, 1'b0, 1'b0, 1'b0}, // R5 unlimited
        '{4'd5, 1'b0, 2'd3, 3'd1, 1'b1, 7'd16,  3'd0, 8'd0, 1'b0, 1'b0, 1'b0},
        '{4'd5, 1'b0, 2'd3, 3'd1, 1'b1, 7'd127, 3'd0, 8'd0, 1'b0, 1'b0, 1'b0},
        '{4'd6, 1'b0, 2'd2, 3'd1, 1'b1, 7'd3,   3'd1, 8'd0, 1'b1, 1'b0, 1'b0}, // R6
        '{4'd6, 1'b0, 2'd3, 3'd1, 1'b1, 7'd4,   3'd1, 8'd0, 1'b1, 1'b0, 1'b0},
        '{4'd7, 1'b0, 2'd2, 3'd1, 1'b1, 7'd1,   3'd2, 8'd0, 1'b0, 1'b0, 1'b0}, // R7 4-beat
        '{4'd7, 1'b0, 2'd3, 3'd1, 1'b1, 7'd2,   3'd2, 8'd0, 1'b0, 1'b0, 1'b0},
        '{4'd7, 1'b0, 2'd3, 3'd1, 1'b1, 7'd3,   3'd2, 8'd0, 1'b1, 1'b0, 1'b0},
        '{4'd7, 1'b0, 2'd3, 3'd1, 1'b1, 7'd4,   3'd2, 8'd0, 1'b0, 1'b0, 1'b0},
        '{4'd7, 1'b0, 2'd3, 3'd1, 1'b1, 7'd3,   3'd3, 8'd0, 1'b0, 1'b0, 1'b0}, // R7 8-beat
        '{4'd7, 1'b0, 2'd3, 3'd1, 1'b1, 7'd7,   3'd3, 8'd0, 1'b1, 1'b0, 1'b0},
        '{4'd7, 1'b0, 2'd3, 3'd1, 1'b1, 7'd15,  3'd4, 8'd0, 1'b1, 1'b0, 1'b0}, // R7 16-beat
        '{4'd7, 1'b0, 2'd3, 3'd1, 1'b1, 7'd23,  3'd4, 8'd0, 1'b0, 1'b0, 1'b0},
        '{4'd8, 1'b1, 2'd2, 3'd1, 1'b1, 7'd0,   3'd0, 8'd3, 1'b0, 1'b0, 1'b0}, // R8 beat 1
        '{4'd8, 1'b0, 2'd3, 3'd1, 1'b1, 7'd1,   3'd0, 8'd3, 1'b0, 1'b0, 1'b0},
        '{4'd8, 1'b0, 2'd3, 3'd1, 1'b1, 7'd2,   3'd0, 8'd3, 1'b0, 1'b1, 1'b0}, // R8 at limit
        '{4'd8, 1'b0, 2'd3, 3'd1, 1'b1, 7'd3,   3'd0, 8'd3, 1'b0, 1'b1, 1'b0}, // R8 past limit
        '{4'd1, 1'b0, 2'd1, 3'd1, 1'b1, 7'd3,   3'd0, 8'd3, 1'b0, 1'b0, 1'b0},
        '{4'd9, 1'b1, 2'd2, 3'd1, 1'b1, 7'd0,   3'd0, 8'd3, 1'b0, 1'b0, 1'b0}, // R9 regrant
        '{4'd1, 1'b0, 2'd0, 3'd0, 1'b1, 7'd0,   3'd0, 8'd3, 1'b0, 1'b0, 1'b0},
        '{4'd8, 1'b0, 2'd2, 3'd0, 1'b1, 7'd0,   3'd0, 8'd3, 1'b1, 1'b0, 1'b1},
        '{4'd8, 1'b0, 2'd2, 3'd0, 1'b1, 7'd0,   3'd0, 8'd3, 1'b1, 1'b1, 1'b1},
        '{4'd8, 1'b0, 2'd2, 3'd0, 1'b1, 7'd0,   3'd0, 8'd0, 1'b1, 1'b0, 1'b1}, // R8 limit 0
        '{4'd9, 1'b1, 2'd2, 3'd0, 1'b1, 7'd0,   3'd0, 8'd1, 1'b1, 1'b1, 1'b1}  // R9 grant+beat
    };

    task automatic drive(input logic g, input logic [1:0] tr, input logic [2:0] hb,
                         input logic hr, input logic [6:0] wa, input logic [2:0] md,
                         input logic [7:0] lim);
        @(negedge clk);
        new_grant = g; htrans = tr; hburst = hb; hready = hr;
        waddr = wa; ulbt_mode = md; slot_limit = lim;
        #5;
    endtask

    task automatic check(input int req, input logic e, input logic s, input logic si);
        n_run++;
        if ({end_of_burst, slot_limit_hit, single_access} !== {e, s, si}) begin
            n_fail++;
            $display("FAIL R%0d: eob/slot/single got %b%b%b expected %b%b%b",
                     req, end_of_burst, slot_limit_hit, single_access, e, s, si);
        end
    endtask

    initial begin
        // R1 reset: outputs quiet while reset holds, even with a live single beat
        drive(1'b0, 2'd2, 3'd0, 1'b1, 7'd0, 3'd0, 8'd1);
        check(1, 1'b0, 1'b0, 1'b0);
        drive(1'b0, 2'd0, 3'd0, 1'b1, 7'd0, 3'd0, 8'd0);
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            drive(VEC[i].g, VEC[i].tr, VEC[i].hb, VEC[i].hr, VEC[i].wa,
                  VEC[i].md, VEC[i].lim);
            check(int'(VEC[i].req), VEC[i].e, VEC[i].s, VEC[i].si);
        end

        // build up budget and open an INCR4, then reset in the middle (R8, R3)
        drive(1'b0, 2'd2, 3'd3, 1'b1, 7'd0, 3'd0, 8'd0);
        drive(1'b0, 2'd3, 3'd3, 1'b1, 7'd1, 3'd0, 8'd0);
        @(negedge clk);
        rst_n = 1'b0;
        htrans = 2'd0;
        @(negedge clk);
        rst_n = 1'b1;
        drive(1'b0, 2'd2, 3'd3, 1'b1, 7'd0, 3'd0, 8'd2);
        check(8, 1'b0, 1'b0, 1'b0);   // R8 count cleared by reset
        drive(1'b0, 2'd3, 3'd3, 1'b1, 7'd1, 3'd0, 8'd2);
        check(8, 1'b0, 1'b1, 1'b0);
        drive(1'b0, 2'd3, 3'd3, 1'b1, 7'd2, 3'd0, 8'd2);
        check(3, 1'b0, 1'b1, 1'b0);   // R3 fresh count after reset
        drive(1'b0, 2'd3, 3'd3, 1'b1, 7'd3, 3'd0, 8'd2);
        check(3, 1'b1, 1'b1, 1'b0);

        // R7 128-beat boundary uses the top address bit
        drive(1'b1, 2'd2, 3'd1, 1'b1, 7'd63, 3'd7, 8'd0);
        check(7, 1'b0, 1'b0, 1'b0);
        drive(1'b0, 2'd3, 3'd1, 1'b1, 7'd127, 3'd7, 8'd0);
        check(7, 1'b1, 1'b0, 1'b0);
        drive(1'b0, 2'd3, 3'd1, 1'b1, 7'd31, 3'd6, 8'd0);   // R7 64-beat
        check(7, 1'b0, 1'b0, 1'b0);
        drive(1'b0, 2'd3, 3'd1, 1'b1, 7'd63, 3'd6, 8'd0);
        check(7, 1'b1, 1'b0, 1'b0);

        drive(1'b0, 2'd0, 3'd0, 1'b1, 7'd0, 3'd0, 8'd0);
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog: run did not complete, got hang expected finish");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end
endmodule